// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Prescaler

This block is the input stage of one motion axis. It takes the A, B and index lines from an encoder, brings them into the system clock domain, filters out short noise pulses, and turns the filtered levels into single-cycle count strobes with a direction bit. A counter block downstream accumulates those strobes. The block also reports index events and noise errors.

Filtering runs on a slow sampling rate set by an 8-bit divisor. With divisor n, the filter samples once every n+1 system clock cycles. That sampling rate has to be more than eight times the A or B input frequency. An input level is accepted only after it has been seen unchanged on three consecutive samples. Four resolutions are selectable. x1 counts rising edges of A. x2 counts both edges of A. x4 counts every edge of A and of B. The fourth, pulse/direction mode, counts rising edges of A and takes the direction from B. Pulse/direction mode bypasses the filter for counting and never reports errors.

The outputs are plain single-cycle strobes with no valid/ready handshake and no back-pressure. The counter block must accept a strobe on every cycle in which one appears, because nothing is queued or held. `dir` is meaningful in a cycle where `count_en` is high, and it holds its value between strobes.

Top module: `qdec_front`

## Requirements
- R1: An internal sampling tick occurs once every `psc_div`+1 system clock cycles, for `psc_div` from 0 to 255. A pulse that spans fewer than three ticks is rejected at any divisor.
- R2: A filtered input changes level only after the new level has been sampled on 3 consecutive ticks. A pulse lasting 2 ticks causes no count, and a pulse lasting 3 ticks is accepted.
- R3: With `psc_div`=0 in a quadrature mode, `count_en` is high during the cycle after the 6th rising clock edge that follows an input change. In pulse mode this happens after the 3rd edge.
- R4: x4 mode (`qmode`=2'b11) gives one strobe for each accepted edge of A or of B. `dir`=1 (up) when A leads B: an A edge whose new level differs from B, or a B edge whose new level equals A.
- R5: x2 mode (`qmode`=2'b10) gives one strobe for each accepted edge of A, with `dir` = A xor B after the edge. B edges do not count.
- R6: x1 mode (`qmode`=2'b01) gives a strobe only on an accepted rising edge of A, with `dir` = not B.
- R7: Pulse mode (`qmode`=2'b00) gives one strobe for each rising edge of the synchronized, unfiltered A, with `dir` = B (1 = up).
- R8: In quadrature modes, `error_evt` pulses for one cycle when a sampled input changes again before its new level has been accepted.
- R9: In quadrature modes, if A and B are accepted on the same tick, `error_evt` pulses and no count is produced.
- R10: In pulse mode, `error_evt` stays low whatever the inputs do.
- R11: `index_evt` pulses for one cycle when the filtered index reaches the level given by `idx_pol`. A rejected index pulse gives no event in any mode.
- R12: During and right after reset, `count_en`, `dir`, `index_evt` and `error_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psc_div | input | 8 | Sampling divisor n; one tick every n+1 cycles |
| qmode | input | 2 | 00 pulse/dir, 01 x1, 10 x2, 11 x4 |
| idx_pol | input | 1 | Active level of the index input |
| in_a | input | 1 | Encoder channel A, asynchronous |
| in_b | input | 1 | Encoder channel B, asynchronous |
| in_idx | input | 1 | Encoder index, asynchronous |
| count_en | output | 1 | Single-cycle count strobe |
| dir | output | 1 | Count direction, 1 = up |
| index_evt | output | 1 | Single-cycle index event |
| error_evt | output | 1 | Single-cycle noise/timing error |

## Verification
With a divisor of 0, a quadrature edge takes 6 register stages to reach `count_en`: two synchronizer stages, three filter samples, and the output register. A pulse-mode edge takes 3 stages. The exact-latency checks sample at the falling edge after the 5th and the 6th rising edges, or after the 2nd and 3rd in pulse mode, so the strobe is seen to be absent and then present. All other checks let a monitor count strobes, errors and index events at each rising edge during a window longer than the worst-case latency for the divisor in use. The tally is then compared with the expected count once the window closes. At divisor 255 the windows run to 1100 cycles, which covers three ticks plus the fixed stages.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    QM_PULSE = 2'b00,
    QM_X1    = 2'b01,
    QM_X2    = 2'b10,
    QM_X4    = 2'b11
  } qmode_e;

  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_IDX = 2;
  localparam int NUM_CH = 3;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= raw_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= div_i;
    else             cnt_q <= cnt_q - 1'b1;
  end

  // R1: a nonzero divisor never yields ticks on back-to-back cycles
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/qdec_chan_filter.sv
module qdec_chan_filter #(
  parameter int STABLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic din_i,
  output logic level_o,
  output logic chg_o,
  output logic glitch_o
);
  localparam int RUN_W = (STABLE_TICKS > 2) ? $clog2(STABLE_TICKS) : 1;
  localparam logic [RUN_W-1:0] RUN_MAX    = RUN_W'(STABLE_TICKS - 1);
  localparam logic [RUN_W-1:0] RUN_ACCEPT = RUN_W'(STABLE_TICKS - 2);

  logic             cand_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= 1'b0;
      run_q    <= RUN_MAX;
      level_o  <= 1'b0;
      chg_o    <= 1'b0;
      glitch_o <= 1'b0;
    end else begin
      chg_o    <= 1'b0;
      glitch_o <= 1'b0;
      if (tick_i) begin
        if (din_i != cand_q) begin
          cand_q   <= din_i;
          run_q    <= '0;
          glitch_o <= (cand_q != level_o);
        end else begin
          if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
          if (run_q == RUN_ACCEPT && cand_q != level_o) begin
            level_o <= cand_q;
            chg_o   <= 1'b1;
          end
        end
      end
    end
  end

  // R2: an accepted change only follows a sampling tick
  assert_accept_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> $past(tick_i));
  // R2: the change strobe always comes with a real level flip
  assert_accept_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> (level_o != $past(level_o)));
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode_i,
  input  logic           idx_pol_i,
  input  logic [NCH-1:0] level_i,
  input  logic [NCH-1:0] chg_i,
  input  logic [NCH-1:0] glitch_i,
  input  logic           raw_a_i,
  input  logic           raw_b_i,
  output logic           count_en,
  output logic           dir,
  output logic           index_evt,
  output logic           error_evt
);
  qmode_e mode;
  logic   a_lvl, b_lvl, a_chg, b_chg, pair;
  logic   raw_a_q, hit, dir_n, err_n, idx_n;

  assign mode  = qmode_e'(mode_i);
  assign a_lvl = level_i[CH_A];
  assign b_lvl = level_i[CH_B];
  assign a_chg = chg_i[CH_A];
  assign b_chg = chg_i[CH_B];
  assign pair  = a_chg & b_chg;

  always_comb begin
    hit   = 1'b0;
    dir_n = dir;
    unique case (mode)
      QM_PULSE: begin
        hit   = raw_a_i & ~raw_a_q;
        dir_n = raw_b_i;
      end
      QM_X1: begin
        hit   = a_chg & a_lvl & ~b_chg;
        dir_n = ~b_lvl;
      end
      QM_X2: begin
        hit   = a_chg & ~b_chg;
        dir_n = a_lvl ^ b_lvl;
      end
      QM_X4: begin
        hit   = a_chg ^ b_chg;
        dir_n = a_chg ? (a_lvl ^ b_lvl) : ~(a_lvl ^ b_lvl);
      end
      default: hit = 1'b0;
    endcase
    err_n = (mode != QM_PULSE) & ((|glitch_i) | pair);
    idx_n = chg_i[CH_IDX] & (level_i[CH_IDX] == idx_pol_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_a_q   <= 1'b0;
      count_en  <= 1'b0;
      dir       <= 1'b0;
      index_evt <= 1'b0;
      error_evt <= 1'b0;
    end else begin
      raw_a_q   <= raw_a_i;
      count_en  <= hit;
      if (hit) dir <= dir_n;
      index_evt <= idx_n;
      error_evt <= err_n;
    end
  end

  // R9: a same-tick A/B acceptance in a quadrature mode produces no count
  assert_pair_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pair && mode != QM_PULSE) |=> !count_en);
  // R10: pulse mode never reports an error
  assert_pulse_no_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == QM_PULSE) |=> !error_evt);
  // R6: x1 counts nothing but an accepted rising A
  assert_x1_rise_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == QM_X1 && !(a_chg && a_lvl)) |=> !count_en);
endmodule

// File: rtl/qdec_front.sv
module qdec_front
  import qdec_pkg::*;
#(
  parameter int PSC_W        = 8,
  parameter int STABLE_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_div,
  input  logic [1:0]       qmode,
  input  logic             idx_pol,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_idx,
  output logic             count_en,
  output logic             dir,
  output logic             index_evt,
  output logic             error_evt
);
  logic              tick;
  logic [NUM_CH-1:0] raw_v, sync_v, level_v, chg_v, glitch_v;

  assign raw_v = {in_idx, in_b, in_a};

  qdec_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_v), .sync_o(sync_v)
  );

  qdec_prescaler #(.DIV_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .div_i(psc_div), .tick_o(tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    qdec_chan_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .din_i(sync_v[c]),
      .level_o(level_v[c]), .chg_o(chg_v[c]), .glitch_o(glitch_v[c])
    );
  end

  qdec_decode #(.NCH(NUM_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode_i(qmode), .idx_pol_i(idx_pol),
    .level_i(level_v), .chg_i(chg_v), .glitch_i(glitch_v),
    .raw_a_i(sync_v[CH_A]), .raw_b_i(sync_v[CH_B]),
    .count_en(count_en), .dir(dir), .index_evt(index_evt), .error_evt(error_evt)
  );

  // R12: no strobe is ever issued in the first cycle out of reset
  assert_quiet_after_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(count_en || error_evt || index_evt));
endmodule

// File: tb/qdec_front_test.sv
`timescale 1ns/1ps
module qdec_front_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] psc_div = 8'd0;
  logic [1:0] qmode = 2'b11;
  logic       idx_pol = 1'b1;
  logic       in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
  logic       count_en, dir, index_evt, error_evt;

  int n_chk = 0, n_bad = 0;
  int up_cnt = 0, dn_cnt = 0, err_cnt = 0, idx_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qdec_front uut (
    .clk(clk), .rst_n(rst_n), .psc_div(psc_div), .qmode(qmode), .idx_pol(idx_pol),
    .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
    .count_en(count_en), .dir(dir), .index_evt(index_evt), .error_evt(error_evt)
  );

  // {mode[7:6], a[5], b[4], ups[3:2], downs[1:0]}
  localparam int NV = 30;
  localparam logic [7:0] VEC [NV] = '{
    8'b11_1_0_01_00, 8'b11_1_1_01_00, 8'b11_0_1_01_00, 8'b11_0_0_01_00,
    8'b11_0_1_00_01, 8'b11_1_1_00_01, 8'b11_1_0_00_01, 8'b11_0_0_00_01,
    8'b10_1_0_01_00, 8'b10_1_1_00_00, 8'b10_0_1_01_00, 8'b10_0_0_00_00,
    8'b10_0_1_00_00, 8'b10_1_1_00_01, 8'b10_1_0_00_00, 8'b10_0_0_00_01,
    8'b01_1_0_01_00, 8'b01_1_1_00_00, 8'b01_0_1_00_00, 8'b01_0_0_00_00,
    8'b01_0_1_00_00, 8'b01_1_1_00_01, 8'b01_1_0_00_00, 8'b01_0_0_00_00,
    8'b00_0_1_00_00, 8'b00_1_1_01_00, 8'b00_0_1_00_00, 8'b00_0_0_00_00,
    8'b00_1_0_00_01, 8'b00_0_0_00_00
  };

  always @(posedge clk) begin
    if (rst_n) begin
      if (count_en) begin
        if (dir) up_cnt++;
        else     dn_cnt++;
      end
      if (error_evt) err_cnt++;
      if (index_evt) idx_cnt++;
    end
  end

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'b11:   return "R4 x4";
      2'b10:   return "R5 x2";
      2'b01:   return "R6 x1";
      default: return "R7 pulse";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_win();
    up_cnt = 0; dn_cnt = 0; err_cnt = 0; idx_cnt = 0;
  endtask

  task automatic expect_win(input string tag, input int up, input int dn, input int er);
    check({tag, " ups"}, up_cnt, up);
    check({tag, " downs"}, dn_cnt, dn);
    check({tag, " errors"}, err_cnt, er);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check("R12 count_en in reset", int'(count_en), 0);
    check("R12 error_evt in reset", int'(error_evt), 0);
    rst_n = 1'b1;
    cycles(1);
    check("R12 count_en", int'(count_en), 0);
    check("R12 dir", int'(dir), 0);
    check("R12 index_evt", int'(index_evt), 0);
    check("R12 error_evt", int'(error_evt), 0);
    cycles(10);

    // table walk, divisor 0
    for (int i = 0; i < NV; i++) begin
      clear_win();
      qmode = VEC[i][7:6];
      in_a  = VEC[i][5];
      in_b  = VEC[i][4];
      cycles(12);
      expect_win($sformatf("%s vec %0d", mtag(VEC[i][7:6]), i),
                 int'(VEC[i][3:2]), int'(VEC[i][1:0]), 0);
    end

    // R3: exact latency in x4
    qmode = 2'b11; cycles(4);
    in_a = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R3 x4 strobe not before 6th edge", int'(count_en), 0);
    @(negedge clk);
    check("R3 x4 strobe after 6th edge", int'(count_en), 1);
    check("R3 x4 dir up", int'(dir), 1);
    in_a = 1'b0; cycles(12);

    // R3: exact latency in pulse mode
    qmode = 2'b00; in_b = 1'b1; cycles(6);
    in_a = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 pulse strobe not before 3rd edge", int'(count_en), 0);
    @(negedge clk);
    check("R3 pulse strobe after 3rd edge", int'(count_en), 1);
    in_a = 1'b0; in_b = 1'b0; cycles(12);

    // R2 / R8: 2-tick pulse rejected and flagged
    qmode = 2'b11; cycles(4); clear_win();
    in_a = 1'b1; cycles(2); in_a = 1'b0; cycles(14);
    expect_win("R2 R8 two-tick pulse", 0, 0, 1);

    // R2: 3-tick pulse accepted
    clear_win();
    in_a = 1'b1; cycles(3); in_a = 1'b0; cycles(14);
    expect_win("R2 three-tick pulse", 1, 1, 0);

    // R9: A and B accepted together
    clear_win();
    in_a = 1'b1; in_b = 1'b1; cycles(14);
    expect_win("R9 same-tick rise", 0, 0, 1);
    clear_win();
    in_a = 1'b0; in_b = 1'b0; cycles(14);
    expect_win("R9 same-tick fall", 0, 0, 1);

    // R10: pulse mode never flags errors
    qmode = 2'b00; in_b = 1'b1; cycles(6); clear_win();
    in_a = 1'b1; cycles(2); in_a = 1'b0; cycles(14);
    expect_win("R10 pulse-mode glitch", 1, 0, 0);
    in_b = 1'b0; cycles(14); clear_win();
    in_a = 1'b1; in_b = 1'b1; cycles(14);
    expect_win("R10 pulse-mode joint change", 1, 0, 0);
    in_a = 1'b0; in_b = 1'b0; cycles(14);

    // R11: index polarity and filtering
    qmode = 2'b11; idx_pol = 1'b1; cycles(4); clear_win();
    in_idx = 1'b1; cycles(14);
    check("R11 active-high rise event", idx_cnt, 1);
    clear_win(); in_idx = 1'b0; cycles(14);
    check("R11 active-high fall no event", idx_cnt, 0);
    idx_pol = 1'b0; clear_win();
    in_idx = 1'b1; cycles(14);
    check("R11 active-low rise no event", idx_cnt, 0);
    clear_win(); in_idx = 1'b0; cycles(14);
    check("R11 active-low fall event", idx_cnt, 1);
    qmode = 2'b00; idx_pol = 1'b1; cycles(4); clear_win();
    in_idx = 1'b1; cycles(2); in_idx = 1'b0; cycles(14);
    check("R11 short index pulse filtered in pulse mode", idx_cnt, 0);

    // R1: divisor 3
    qmode = 2'b11; psc_div = 8'd3; cycles(20); clear_win();
    in_a = 1'b1; cycles(6); in_a = 1'b0; cycles(40);
    expect_win("R1 div3 six-cycle pulse", 0, 0, 1);
    clear_win(); in_a = 1'b1; cycles(40);
    expect_win("R1 div3 held rise", 1, 0, 0);
    clear_win(); in_a = 1'b0; cycles(40);
    expect_win("R1 div3 held fall", 0, 1, 0);

    // R1: divisor 255
    psc_div = 8'd255; cycles(600); clear_win();
    in_a = 1'b1; cycles(300); in_a = 1'b0; cycles(1100);
    expect_win("R1 div255 300-cycle pulse", 0, 0, 1);
    clear_win(); in_a = 1'b1; cycles(1100);
    expect_win("R1 div255 held rise", 1, 0, 0);
    clear_win(); in_a = 1'b0; cycles(1100);
    expect_win("R1 div255 held fall", 0, 1, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule